// File: doc/BRIEF.md
# Root Hub Port Routing Controller

This block sits between the downstream ports of a USB 2.0 root hub and three host cores: one high-speed core and two full/low-speed companion cores. For every port it decides which core owns the port. That core sees the connect line of the port and receives its status-change indications. Ports with odd numbers belong by default to companion A and ports with even numbers belong to companion B. The high-speed core can take any port.

Software controls the block through a small register file with write and read strobes. The registers hold a global flag that hands ports to the high-speed core, per-port bits that return a port to its companion, the number of live ports, per-port power requests, and sticky status bits. Each port has an active-low overcurrent input, which is synchronized before use and which switches off the power of that port. Ports above the configured count are treated as absent.

Top module: `hub_port_router`

## Requirements
- R1: After reset the flag is clear, the port count is 5, no port is powered, every port is owned by its companion, and all status bits and change outputs are zero. A read of the configuration word returns 8'hA0.
- R2: With the flag clear, each live port is owned by its companion. On `port_owner`, port n uses bits [2n-1:2n-2] with the codes 00 absent, 01 companion A, 10 companion B and 11 high-speed core. Ports 1, 3 and 5 code 01. Ports 2 and 4 code 10.
- R3: With the flag set, every live port is owned by the high-speed core (code 11), except a port whose return bit is 1. That port goes back to its companion.
- R4: The configuration word sits at address 0. Bit 0 is the flag and bits [7:5] are the port count. A written count below 2 is stored as 2, and a written count above 5 is stored as 5. A read returns the stored values.
- R5: A port whose number exceeds the count is absent. It codes 00, is never powered, shows no connect to any core, and its overcurrent input has no effect.
- R6: Address 2 holds the power requests, bit n-1 for port n. `port_pwr_en` is high only for a live port whose request is set and that has no synchronized overcurrent.
- R7: The overcurrent input passes through two flops. If it is held low for two edges, power is off after the second edge and the request bit is cleared. The bit for that port at address 3 is set while the overcurrent persists and stays set until a 1 is written to it. Address 4 reads the synchronized overcurrent level of the live ports.
- R8: When the owner of a port changes to a core (code other than 00), that port's bit at address 5 is set on the next edge. A write of 1 clears the bit, and a set in the same cycle wins over the clear.
- R9: Each core's change output is high while any bit at address 5 is set for a port that core currently owns.
- R10: Each port's connect input appears only on the connect vector of the core that owns the port, at the same bit position.
- R11: `reg_rdata` is registered. It holds the addressed word in the cycle after a read strobe and is zero otherwise. Addresses 1 (return bits), 2 and 5 read back their registers, and addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| port_oc_n | input | 5 | Per-port overcurrent, active low |
| port_pwr_en | output | 5 | Per-port power enable, active high |
| port_conn | input | 5 | Per-port connect status from transceivers |
| port_owner | output | 10 | Per-port owner code, 2 bits per port |
| hs_conn | output | 5 | Connect vector seen by the high-speed core |
| cmpa_conn | output | 5 | Connect vector seen by companion A |
| cmpb_conn | output | 5 | Connect vector seen by companion B |
| hs_chg | output | 1 | Status change toward the high-speed core |
| cmpa_chg | output | 1 | Status change toward companion A |
| cmpb_chg | output | 1 | Status change toward companion B |

## Verification
The hardest situation to create is when several things hit the same cycle. Examples are a write-one-clear of the change bit landing while an ownership flip sets it again, or an overcurrent that arrives while software is writing the power request of the same port. It is equally hard to make a port go absent and come back while it is flagged or powered. The stimulus mixes directed steps, which clamp the count to 2 and back to 5 and hold an overcurrent across a power write, with a long seeded random run. In that run, writes to every address, random clear masks, slowly toggling overcurrent lines and connect changes overlap freely. A cycle-level model checks every output on every cycle.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
   typedef enum logic [1:0] {
      OWN_NONE = 2'b00,
      OWN_CMPA = 2'b01,
      OWN_CMPB = 2'b10,
      OWN_HS   = 2'b11
   } owner_e;

   localparam int REG_CFG = 0;
   localparam int REG_RET = 1;
   localparam int REG_PWR = 2;
   localparam int REG_OCC = 3;
   localparam int REG_OCL = 4;
   localparam int REG_CSC = 5;
endpackage

// File: rtl/hpr_oc_sync.sv
module hpr_oc_sync #(
   parameter int NUM_PORTS = 5,
   parameter int STAGES    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] oc_n_i,
   output logic [NUM_PORTS-1:0] oc_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hpr_oc_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], ~oc_n_i[i]};
         end
         assign oc_o[i] = sh_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hpr_route.sv
module hpr_route
   import hpr_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int CNT_W     = 3
) (
   input  logic [CNT_W-1:0]       cnt_i,
   input  logic                   hs_cfg_i,
   input  logic [NUM_PORTS-1:0]   ret_i,
   input  logic [NUM_PORTS-1:0]   conn_i,
   output logic [NUM_PORTS-1:0]   live_o,
   output logic [2*NUM_PORTS-1:0] owner_o,
   output logic [NUM_PORTS-1:0]   hs_conn_o,
   output logic [NUM_PORTS-1:0]   a_conn_o,
   output logic [NUM_PORTS-1:0]   b_conn_o
);
   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
         owner_e home_w;
         owner_e own_w;
         logic   live_w;

         if (i % 2 == 0) begin : g_odd_num
            assign home_w = OWN_CMPA;
         end else begin : g_even_num
            assign home_w = OWN_CMPB;
         end

         always_comb begin
            live_w = (CNT_W'(i) < cnt_i);
            if (!live_w)                    own_w = OWN_NONE;
            else if (hs_cfg_i && !ret_i[i]) own_w = OWN_HS;
            else                            own_w = home_w;
         end

         assign live_o[i]         = live_w;
         assign owner_o[2*i +: 2] = own_w;
         assign hs_conn_o[i]      = conn_i[i] && (own_w == OWN_HS);
         assign a_conn_o[i]       = conn_i[i] && (own_w == OWN_CMPA);
         assign b_conn_o[i]       = conn_i[i] && (own_w == OWN_CMPB);
      end
   endgenerate
endmodule

// File: rtl/hpr_regs.sv
module hpr_regs
   import hpr_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int MIN_PORTS = 2,
   parameter int CNT_W     = 3,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_i,
   input  logic                   rd_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [DATA_W-1:0]      wdata_i,
   output logic [DATA_W-1:0]      rdata_o,
   input  logic [NUM_PORTS-1:0]   live_i,
   input  logic [2*NUM_PORTS-1:0] owner_i,
   input  logic [NUM_PORTS-1:0]   oc_i,
   output logic                   hs_cfg_o,
   output logic [CNT_W-1:0]       cnt_o,
   output logic [NUM_PORTS-1:0]   ret_o,
   output logic [NUM_PORTS-1:0]   preq_o,
   output logic [NUM_PORTS-1:0]   occ_o,
   output logic [NUM_PORTS-1:0]   csc_o
);
   localparam int              CNT_LSB = DATA_W - CNT_W;
   localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_PORTS);
   localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(NUM_PORTS);

   function automatic logic [2*NUM_PORTS-1:0] reset_owner();
      logic [2*NUM_PORTS-1:0] v;
      for (int i = 0; i < NUM_PORTS; i++)
         v[2*i +: 2] = (i % 2 == 0) ? OWN_CMPA : OWN_CMPB;
      return v;
   endfunction

   function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v);
      if (v < MIN_C)      return MIN_C;
      else if (v > MAX_C) return MAX_C;
      else                return v;
   endfunction

   logic                   hs_cfg_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [NUM_PORTS-1:0]   ret_q, preq_q, occ_q, csc_q;
   logic [2*NUM_PORTS-1:0] prev_q;
   logic [NUM_PORTS-1:0]   oc_live, own_set, occ_clr, csc_clr;
   logic                   wr_cfg, wr_ret, wr_pwr;
   logic [DATA_W-1:0]      cfg_word;

   assign wr_cfg  = wr_i && (addr_i == ADDR_W'(REG_CFG));
   assign wr_ret  = wr_i && (addr_i == ADDR_W'(REG_RET));
   assign wr_pwr  = wr_i && (addr_i == ADDR_W'(REG_PWR));
   assign occ_clr = (wr_i && addr_i == ADDR_W'(REG_OCC)) ? wdata_i[NUM_PORTS-1:0] : '0;
   assign csc_clr = (wr_i && addr_i == ADDR_W'(REG_CSC)) ? wdata_i[NUM_PORTS-1:0] : '0;
   assign oc_live = oc_i & live_i;

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chg
         assign own_set[i] = (owner_i[2*i +: 2] != prev_q[2*i +: 2]) &&
                             (owner_i[2*i +: 2] != OWN_NONE);
      end
   endgenerate

   always_comb begin
      cfg_word                  = '0;
      cfg_word[0]               = hs_cfg_q;
      cfg_word[CNT_LSB +: CNT_W] = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_cfg_q <= 1'b0;
         cnt_q    <= MAX_C;
         ret_q    <= '0;
         preq_q   <= '0;
         occ_q    <= '0;
         csc_q    <= '0;
         prev_q   <= reset_owner();
      end else begin
         if (wr_cfg) begin
            hs_cfg_q <= wdata_i[0];
            cnt_q    <= clamp_cnt(wdata_i[CNT_LSB +: CNT_W]);
         end
         if (wr_ret) ret_q <= wdata_i[NUM_PORTS-1:0];
         preq_q <= (wr_pwr ? wdata_i[NUM_PORTS-1:0] : preq_q) & ~oc_live;
         occ_q  <= (occ_q & ~occ_clr) | oc_live;
         csc_q  <= (csc_q & ~csc_clr) | own_set;
         prev_q <= owner_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_o <= '0;
      else if (rd_i) begin
         case (addr_i)
            ADDR_W'(REG_CFG): rdata_o <= cfg_word;
            ADDR_W'(REG_RET): rdata_o <= DATA_W'(ret_q);
            ADDR_W'(REG_PWR): rdata_o <= DATA_W'(preq_q);
            ADDR_W'(REG_OCC): rdata_o <= DATA_W'(occ_q);
            ADDR_W'(REG_OCL): rdata_o <= DATA_W'(oc_live);
            ADDR_W'(REG_CSC): rdata_o <= DATA_W'(csc_q);
            default:          rdata_o <= '0;
         endcase
      end else rdata_o <= '0;
   end

   assign hs_cfg_o = hs_cfg_q;
   assign cnt_o    = cnt_q;
   assign ret_o    = ret_q;
   assign preq_o   = preq_q;
   assign occ_o    = occ_q;
   assign csc_o    = csc_q;

   // R4
   cnt_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q >= MIN_C) && (cnt_q <= MAX_C));

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_sticky
         // R7
         occ_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            occ_q[i] && !(wr_i && addr_i == ADDR_W'(REG_OCC) && wdata_i[i]) |=> occ_q[i]);
         // R8
         csc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            csc_q[i] && !(wr_i && addr_i == ADDR_W'(REG_CSC) && wdata_i[i]) |=> csc_q[i]);
      end
   endgenerate
endmodule

// File: rtl/hub_port_router.sv
module hub_port_router
   import hpr_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int MIN_PORTS = 2,
   parameter int SYNC_STG  = 2,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic                   reg_rd,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata,
   input  logic [NUM_PORTS-1:0]   port_oc_n,
   output logic [NUM_PORTS-1:0]   port_pwr_en,
   input  logic [NUM_PORTS-1:0]   port_conn,
   output logic [2*NUM_PORTS-1:0] port_owner,
   output logic [NUM_PORTS-1:0]   hs_conn,
   output logic [NUM_PORTS-1:0]   cmpa_conn,
   output logic [NUM_PORTS-1:0]   cmpb_conn,
   output logic                   hs_chg,
   output logic                   cmpa_chg,
   output logic                   cmpb_chg
);
   localparam int CNT_W = $clog2(NUM_PORTS + 1);

   generate
      if (MIN_PORTS < 1 || MIN_PORTS > NUM_PORTS) begin : g_bad_min
         $error("hub_port_router: MIN_PORTS out of range");
      end
      if (DATA_W < NUM_PORTS + CNT_W) begin : g_bad_data
         $error("hub_port_router: DATA_W too narrow for port bits and count field");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("hub_port_router: ADDR_W must reach six registers");
      end
   endgenerate

   logic                 hs_cfg;
   logic [CNT_W-1:0]     cnt;
   logic [NUM_PORTS-1:0] ret, preq, occ, csc, oc_s, live;
   logic [NUM_PORTS-1:0] hs_own, a_own, b_own;

   hpr_oc_sync #(.NUM_PORTS(NUM_PORTS), .STAGES(SYNC_STG)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .oc_n_i (port_oc_n),
      .oc_o   (oc_s)
   );

   hpr_route #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_route (
      .cnt_i     (cnt),
      .hs_cfg_i  (hs_cfg),
      .ret_i     (ret),
      .conn_i    (port_conn),
      .live_o    (live),
      .owner_o   (port_owner),
      .hs_conn_o (hs_conn),
      .a_conn_o  (cmpa_conn),
      .b_conn_o  (cmpb_conn)
   );

   hpr_regs #(
      .NUM_PORTS(NUM_PORTS), .MIN_PORTS(MIN_PORTS), .CNT_W(CNT_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (reg_wr),
      .rd_i     (reg_rd),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .rdata_o  (reg_rdata),
      .live_i   (live),
      .owner_i  (port_owner),
      .oc_i     (oc_s),
      .hs_cfg_o (hs_cfg),
      .cnt_o    (cnt),
      .ret_o    (ret),
      .preq_o   (preq),
      .occ_o    (occ),
      .csc_o    (csc)
   );

   assign port_pwr_en = preq & live & ~oc_s;

   always_comb begin
      for (int i = 0; i < NUM_PORTS; i++) begin
         hs_own[i] = (port_owner[2*i +: 2] == OWN_HS);
         a_own[i]  = (port_owner[2*i +: 2] == OWN_CMPA);
         b_own[i]  = (port_owner[2*i +: 2] == OWN_CMPB);
      end
   end

   assign hs_chg   = |(csc & hs_own);
   assign cmpa_chg = |(csc & a_own);
   assign cmpb_chg = |(csc & b_own);

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
         // R5
         absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (port_owner[2*i +: 2] == OWN_NONE) |->
               !port_pwr_en[i] && !hs_conn[i] && !cmpa_conn[i] && !cmpb_conn[i]);
         // R7
         oc_power_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && !port_oc_n[i] && $past(!port_oc_n[i]) |=> !port_pwr_en[i]);
         // R8
         owner_csc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && (port_owner[2*i +: 2] != $past(port_owner[2*i +: 2])) &&
            (port_owner[2*i +: 2] != OWN_NONE) |=> csc[i]);
         // R10
         conn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({hs_conn[i], cmpa_conn[i], cmpb_conn[i]}));
         // R2
         if (i % 2 == 0) begin : g_odd_num
            parity_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
               port_owner[2*i +: 2] != OWN_CMPB);
         end else begin : g_even_num
            parity_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
               port_owner[2*i +: 2] != OWN_CMPA);
         end
      end
   endgenerate
endmodule

// File: tb/test_hub_port_router.sv
module test_hub_port_router;
   localparam int P = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       reg_wr, reg_rd;
   logic [2:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   logic [P-1:0] port_oc_n, port_pwr_en, port_conn, hs_conn, cmpa_conn, cmpb_conn;
   logic [2*P-1:0] port_owner;
   logic hs_chg, cmpa_chg, cmpb_chg;

   always #10 clk = ~clk;

   hub_port_router i_hub_port_router (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .port_oc_n(port_oc_n), .port_pwr_en(port_pwr_en), .port_conn(port_conn),
      .port_owner(port_owner), .hs_conn(hs_conn), .cmpa_conn(cmpa_conn),
      .cmpb_conn(cmpb_conn), .hs_chg(hs_chg), .cmpa_chg(cmpa_chg), .cmpb_chg(cmpb_chg)
   );

   int n_chk = 0, n_fail = 0;

   // model state
   logic         m_hs;
   int           m_cnt;
   logic [P-1:0] m_ret, m_preq, m_occ, m_csc, m_s1, m_s2;
   logic [2*P-1:0] m_prev;
   logic [7:0]   m_rdata;
   int           m_raddr;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [P-1:0] m_live();
      logic [P-1:0] v;
      for (int i = 0; i < P; i++) v[i] = (i < m_cnt);
      return v;
   endfunction

   function automatic logic [1:0] m_owner(input int i);
      if (i >= m_cnt) return 2'b00;
      if (m_hs && !m_ret[i]) return 2'b11;
      return (i % 2 == 0) ? 2'b01 : 2'b10;
   endfunction

   function automatic logic [2*P-1:0] m_owner_vec();
      logic [2*P-1:0] v;
      for (int i = 0; i < P; i++) v[2*i +: 2] = m_owner(i);
      return v;
   endfunction

   function automatic logic [7:0] m_read(input int a);
      case (a)
         0: return {3'(m_cnt), 4'b0, m_hs};
         1: return {3'b0, m_ret};
         2: return {3'b0, m_preq};
         3: return {3'b0, m_occ};
         4: return {3'b0, m_s2 & m_live()};
         5: return {3'b0, m_csc};
         default: return 8'h00;
      endcase
   endfunction

   function automatic int clamp(input int v);
      if (v < 2) return 2;
      if (v > 5) return 5;
      return v;
   endfunction

   task automatic compare_all();
      logic [2*P-1:0] own;
      logic [P-1:0] live, e_hs, e_a, e_b, absm;
      logic [2*P-1:0] absm2;
      logic e_hc, e_ac, e_bc;
      string rtag;
      own  = m_owner_vec();
      live = m_live();
      absm = ~live;
      for (int i = 0; i < P; i++) begin
         e_hs[i] = port_conn[i] && own[2*i +: 2] == 2'b11;
         e_a[i]  = port_conn[i] && own[2*i +: 2] == 2'b01;
         e_b[i]  = port_conn[i] && own[2*i +: 2] == 2'b10;
         absm2[2*i +: 2] = {2{absm[i]}};
      end
      e_hc = |(m_csc & e_mask(own, 2'b11));
      e_ac = |(m_csc & e_mask(own, 2'b01));
      e_bc = |(m_csc & e_mask(own, 2'b10));
      chk(m_hs ? "R3 owner" : "R2 owner", 16'(port_owner), 16'(own));
      chk("R5 absent port", 16'({port_owner & absm2, port_pwr_en & absm}), 16'h0);
      chk((m_s2 != 0) ? "R7 power" : "R6 power", 16'(port_pwr_en), 16'(m_preq & live & ~m_s2));
      chk("R10 connect", 16'({hs_conn, cmpa_conn, cmpb_conn}), 16'({e_hs, e_a, e_b}));
      chk("R9 change out", 16'({hs_chg, cmpa_chg, cmpb_chg}), 16'({e_hc, e_ac, e_bc}));
      case (m_raddr)
         0: rtag = "R4 read cfg";
         3: rtag = "R7 read occ";
         4: rtag = "R7 read level";
         5: rtag = "R8 read csc";
         default: rtag = "R11 read";
      endcase
      chk(rtag, 16'(reg_rdata), 16'(m_rdata));
   endtask

   function automatic logic [P-1:0] e_mask(input logic [2*P-1:0] own, input logic [1:0] code);
      logic [P-1:0] v;
      for (int i = 0; i < P; i++) v[i] = (own[2*i +: 2] == code);
      return v;
   endfunction

   // drive at negedge, advance model across one edge, compare at next negedge
   task automatic cycle(input logic wr, input logic rd, input int a, input logic [7:0] d,
                        input logic [P-1:0] ocn, input logic [P-1:0] conn);
      logic [P-1:0] ocm, n_preq, n_occ, n_csc, set, w_occ, w_csc;
      logic [2*P-1:0] own;
      logic n_hs; int n_cnt; logic [P-1:0] n_ret; logic [7:0] n_rd;
      reg_wr = wr; reg_rd = rd; reg_addr = 3'(a); reg_wdata = d;
      port_oc_n = ocn; port_conn = conn;
      own   = m_owner_vec();
      ocm   = m_s2 & m_live();
      w_occ = (wr && a == 3) ? d[P-1:0] : '0;
      w_csc = (wr && a == 5) ? d[P-1:0] : '0;
      for (int i = 0; i < P; i++)
         set[i] = (own[2*i +: 2] != m_prev[2*i +: 2]) && (own[2*i +: 2] != 2'b00);
      n_preq = ((wr && a == 2) ? d[P-1:0] : m_preq) & ~ocm;
      n_occ  = (m_occ & ~w_occ) | ocm;
      n_csc  = (m_csc & ~w_csc) | set;
      n_hs   = (wr && a == 0) ? d[0] : m_hs;
      n_cnt  = (wr && a == 0) ? clamp(int'(d[7:5])) : m_cnt;
      n_ret  = (wr && a == 1) ? d[P-1:0] : m_ret;
      n_rd   = rd ? m_read(a) : 8'h00;
      @(posedge clk);
      m_preq = n_preq; m_occ = n_occ; m_csc = n_csc; m_prev = own;
      m_hs = n_hs; m_cnt = n_cnt; m_ret = n_ret; m_rdata = n_rd; m_raddr = a;
      m_s2 = m_s1; m_s1 = ~ocn;
      @(negedge clk);
      compare_all();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [P-1:0] ocn, conn;
      void'($urandom(32'h1A2B3C4D));
      rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
      port_oc_n = '1; port_conn = '0;
      m_hs = 0; m_cnt = 5; m_ret = 0; m_preq = 0; m_occ = 0; m_csc = 0;
      m_s1 = 0; m_s2 = 0; m_rdata = 0; m_raddr = 7;
      m_prev = 10'b01_10_01_10_01;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset owner", 16'(port_owner), 16'(10'b01_10_01_10_01));
      chk("R1 reset power", 16'(port_pwr_en), 16'h0);
      chk("R1 reset change", 16'({hs_chg, cmpa_chg, cmpb_chg}), 16'h0);
      chk("R1 reset rdata", 16'(reg_rdata), 16'h0);
      conn = 5'b11111; ocn = '1;
      cycle(0, 1, 0, 0, ocn, conn);
      chk("R1 reset cfg word", 16'(reg_rdata), 16'h00A0);
      cycle(0, 1, 5, 0, ocn, conn);
      // R4 clamp low, flag set: ports 1,2 to high-speed, 3..5 absent
      cycle(1, 0, 0, 8'h01, ocn, conn);
      cycle(0, 1, 0, 0, ocn, conn);
      chk("R4 clamp low", 16'(reg_rdata), 16'h0041);
      cycle(0, 1, 5, 0, ocn, conn);
      chk("R8 owner flip sets bits", 16'(reg_rdata), 16'h0003);
      // R5 absent ports get no power
      cycle(1, 0, 2, 8'h1F, ocn, conn);
      chk("R5 absent unpowered", 16'(port_pwr_en), 16'h0003);
      // R4 clamp high
      cycle(1, 0, 0, 8'hE1, ocn, conn);
      cycle(0, 1, 0, 0, ocn, conn);
      chk("R4 clamp high", 16'(reg_rdata), 16'h00A1);
      cycle(1, 0, 2, 8'h1F, ocn, conn);
      // R3 return port 2 to its companion
      cycle(1, 0, 1, 8'h02, ocn, conn);
      chk("R3 return bit", 16'(port_owner[3:2]), 16'h2);
      // R8 clear and set in same cycle: set wins
      cycle(1, 0, 5, 8'h1F, ocn, conn);
      cycle(1, 0, 1, 8'h00, ocn, conn);
      cycle(1, 0, 5, 8'h02, ocn, conn);
      cycle(0, 1, 5, 0, ocn, conn);
      // R7 overcurrent on port 3, held through a power write
      ocn = 5'b11011;
      cycle(0, 0, 0, 0, ocn, conn);
      cycle(1, 0, 2, 8'h1F, ocn, conn);
      chk("R7 power off after sync", 16'(port_pwr_en[2]), 16'h0);
      cycle(0, 1, 4, 0, ocn, conn);
      ocn = '1;
      cycle(0, 0, 0, 0, ocn, conn);
      cycle(0, 0, 0, 0, ocn, conn);
      cycle(1, 0, 3, 8'h04, ocn, conn);
      cycle(0, 1, 3, 0, ocn, conn);
      chk("R7 sticky cleared", 16'(reg_rdata), 16'h0000);
      cycle(0, 1, 6, 0, ocn, conn);
      // random phase
      for (int k = 0; k < 4000; k++) begin
         int op, a;
         logic [7:0] d;
         op = int'($urandom % 8);
         a  = int'($urandom % 8);
         d  = 8'($urandom);
         if ($urandom % 6 == 0) ocn[$urandom % P] ^= 1'b1;
         if ($urandom % 3 == 0) conn[$urandom % P] ^= 1'b1;
         if (a == 0 && ($urandom % 3 != 0)) a = 2;
         case (op)
            0, 1, 2: cycle(1, 0, a, d, ocn, conn);
            3, 4:    cycle(0, 1, a, d, ocn, conn);
            5:       cycle(1, 1, a, d, ocn, conn);
            default: cycle(0, 0, a, d, ocn, conn);
         endcase
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule